// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer and marks the end of each division period with a single-cycle pulse on `fp`. The count runs through three stages. A prescaler divides by either 10 or 11. A swallow counter holds the prescaler at the larger modulus for a chosen number of its cycles. A main counter counts prescaler cycles and ends the period. With the prescaler in use, one period lasts `10*(M+1)+A` input cycles. With the prescaler bypassed, the main counter counts input cycles directly and one period lasts `M+1` input cycles.

A direct-interface flag clears the two top bits of M before M is used. Software uses this flag when only the lower seven M bits are wired. The divider captures M, A and the bypass select only when a period ends, so a change on the inputs never corrupts the period that is already running. The block sits in the feedback path of a frequency synthesizer, and `fp` goes to the phase comparator.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With `pre_en` low, successive `fp` pulses are `10*(M+1)+A` input cycles apart. In each period, A prescaler cycles last 11 input cycles and the remaining M+1-A last 10.
- R2: M is a 9-bit unsigned value with legal range 1 to 511. The boundary values M=1 (period 20 with A=0) and M=511 divide correctly.
- R3: A is a 4-bit unsigned value and is legal from 0 up to M+1. A=0 and A=M+1 both give the period in R1.
- R4: With `pre_en` high, the prescaler and the A value are out of the path, and `fp` pulses are M+1 input cycles apart whatever A is.
- R5: With `direct_mode` high, M bits 8 and 7 count as zero, so the period uses `m_val[6:0]`. This applies in both the prescaled and the bypass path.
- R6: M, A, `pre_en` and `direct_mode` are sampled only at a period boundary: on the first clock after reset, and on the clock that ends a period. A change between those points affects only the next period.
- R7: `fp` is high for exactly one input cycle. It first rises N cycles after the first clock edge following reset release, where N is the period computed from the inputs sampled at that first edge.
- R8: While `rst_n` is low, `fp` is low and all counters are cleared.
- R9: With A greater than M+1 (an illegal setting) the period length is unspecified, but `fp` keeps pulsing and the divider never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk_in` |
| m_val | input | 9 | Main counter value M |
| a_val | input | 4 | Swallow count A |
| pre_en | input | 1 | High: bypass the prescaler and divide by M+1 |
| direct_mode | input | 1 | High: treat M bits 8 and 7 as zero |
| fp | output | 1 | One-cycle pulse at the end of each division period |

## Verification
The assertions check five properties on every cycle: the prescaler stays within its modulus, the swallow count never rises inside a period, the bypass path ticks the main counter on every cycle, a load in direct mode never leaves the main counter above 127, and `fp` stays low until the divider has started and never lasts two cycles. A gap counter in the checker also bounds the time between pulses, so a stalled divider is caught. The period values themselves, the sampling of new settings only at a boundary, and the first-pulse latency after reset are shown only by the bench. Its behavioural model predicts every `fp` cycle across the prescaled, bypass, direct-mode and mid-period-change scenarios.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  localparam int unsigned PSW_M_W     = 9;
  localparam int unsigned PSW_A_W     = 4;
  localparam int unsigned PSW_DIR_M_W = 7;
  localparam int unsigned PSW_PRE_DIV = 10;

  typedef enum logic {
    PSW_MOD_BASE  = 1'b0,
    PSW_MOD_PLUS1 = 1'b1
  } psw_mod_e;
endpackage

// File: rtl/pswal_prescaler.sv
// Dual-modulus prescaler: divides by PRE_DIV or PRE_DIV+1, or passes every
// enabled cycle through as a tick when bypassed.
module pswal_prescaler
  import pswal_pkg::*;
#(
  parameter int unsigned PRE_DIV = PSW_PRE_DIV
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic                             bypass,
  input  psw_mod_e                         mod_sel,
  output logic                             tick,
  output logic [$clog2(PRE_DIV+1)-1:0]     cnt_o
);
  localparam int unsigned CW = $clog2(PRE_DIV + 1);
  localparam logic [CW-1:0] LAST_BASE  = CW'(PRE_DIV - 1);
  localparam logic [CW-1:0] LAST_PLUS1 = CW'(PRE_DIV);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  always_comb begin
    if (mod_sel == PSW_MOD_PLUS1) begin
      at_last = (cnt_q == LAST_PLUS1);
    end else begin
      at_last = (cnt_q == LAST_BASE);
    end
    tick  = en & (bypass | at_last);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pswal_swallow.sv
// Swallow counter: requests the larger modulus while its count is non-zero.
module pswal_swallow
  import pswal_pkg::*;
#(
  parameter int unsigned A_W = PSW_A_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] load_val,
  input  logic           dec,
  output psw_mod_e       mod_sel,
  output logic [A_W-1:0] cnt_o
);
  logic [A_W-1:0] cnt_q;
  logic [A_W-1:0] cnt_d;
  logic           nonzero;
  logic           cnt_en;

  always_comb begin
    nonzero = |cnt_q;
    mod_sel = nonzero ? PSW_MOD_PLUS1 : PSW_MOD_BASE;
    cnt_en  = load | (dec & nonzero);
    cnt_d   = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pswal_main_ctr.sv
// Main counter: counts prescaler ticks down to zero; terminal count ends a period.
module pswal_main_ctr
  import pswal_pkg::*;
#(
  parameter int unsigned M_W = PSW_M_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [M_W-1:0] load_val,
  input  logic           tick,
  output logic           term,
  output logic [M_W-1:0] cnt_o
);
  logic [M_W-1:0] cnt_q;
  logic [M_W-1:0] cnt_d;
  logic           cnt_en;

  always_comb begin
    term   = tick & (cnt_q == '0);
    cnt_en = load | tick;
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import pswal_pkg::*;
#(
  parameter int unsigned M_W     = PSW_M_W,
  parameter int unsigned A_W     = PSW_A_W,
  parameter int unsigned DIR_M_W = PSW_DIR_M_W,
  parameter int unsigned PRE_DIV = PSW_PRE_DIV
) (
  input  logic           clk_in,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic           pre_en,
  input  logic           direct_mode,
  output logic           fp
);
  localparam int unsigned PCW = $clog2(PRE_DIV + 1);

  logic           running_q;
  logic           byp_q;
  logic           fp_q;
  logic           load;
  logic           pre_tick;
  logic           term;
  psw_mod_e       mod_sel;
  logic [M_W-1:0] m_eff;
  logic [A_W-1:0] a_eff;
  logic [PCW-1:0] pre_cnt;
  logic [A_W-1:0] sw_cnt;
  logic [M_W-1:0] main_cnt;

  // Direct-interface masking of the upper M bits.
  generate
    if (DIR_M_W < M_W) begin : g_mask
      always_comb begin
        m_eff = direct_mode ? {{(M_W-DIR_M_W){1'b0}}, m_val[DIR_M_W-1:0]} : m_val;
      end
    end else begin : g_nomask
      always_comb begin
        m_eff = m_val;
      end
    end
  endgenerate

  always_comb begin
    a_eff = pre_en ? '0 : a_val;   // swallow path idle in bypass
    load  = ~running_q | term;     // start after reset, or period end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
    end else if (!running_q) begin
      running_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else if (load) begin
      byp_q <= pre_en;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      fp_q <= 1'b0;
    end else begin
      fp_q <= term;
    end
  end

  pswal_prescaler #(.PRE_DIV(PRE_DIV)) pre_i (
    .clk     (clk_in),
    .rst_n   (rst_n),
    .en      (running_q),
    .bypass  (byp_q),
    .mod_sel (mod_sel),
    .tick    (pre_tick),
    .cnt_o   (pre_cnt)
  );

  pswal_swallow #(.A_W(A_W)) swl_i (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (a_eff),
    .dec      (pre_tick),
    .mod_sel  (mod_sel),
    .cnt_o    (sw_cnt)
  );

  pswal_main_ctr #(.M_W(M_W)) main_i (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (m_eff),
    .tick     (pre_tick),
    .term     (term),
    .cnt_o    (main_cnt)
  );

  assign fp = fp_q;
endmodule

// File: rtl/pswal_checker.sv
module pswal_checker #(
  parameter int unsigned M_W     = 9,
  parameter int unsigned A_W     = 4,
  parameter int unsigned DIR_M_W = 7,
  parameter int unsigned PRE_DIV = 10,
  parameter int unsigned PCW     = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fp,
  input logic           running,
  input logic           byp,
  input logic           load,
  input logic           direct_mode,
  input logic           pre_tick,
  input logic [PCW-1:0] pre_cnt,
  input logic [A_W-1:0] sw_cnt,
  input logic [M_W-1:0] main_cnt
);
  localparam int unsigned GAP_LIMIT = (PRE_DIV + 1) * (2 ** M_W) + 4;

  int unsigned gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 0;
    end else if (fp) begin
      gap_q <= 0;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  assert_prescale_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= PCW'(PRE_DIV));

  assert_swallow_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load) |=> (sw_cnt <= $past(sw_cnt)));

  assert_bypass_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && byp) |-> pre_tick);

  assert_direct_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && direct_mode) |=> (main_cnt < M_W'(2 ** DIR_M_W)));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !fp);

  assert_no_lockup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < GAP_LIMIT);
endmodule

bind pulse_swallow_divider pswal_checker #(
  .M_W(M_W), .A_W(A_W), .DIR_M_W(DIR_M_W), .PRE_DIV(PRE_DIV), .PCW(PCW)
) chk_i (
  .clk         (clk_in),
  .rst_n       (rst_n),
  .fp          (fp),
  .running     (running_q),
  .byp         (byp_q),
  .load        (load),
  .direct_mode (direct_mode),
  .pre_tick    (pre_tick),
  .pre_cnt     (pre_cnt),
  .sw_cnt      (sw_cnt),
  .main_cnt    (main_cnt)
);

// File: tb/pulse_swallow_divider_tb_top.sv
`timescale 1ns/1ps
module pulse_swallow_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] m_val = 9'd1;
  logic [3:0] a_val = 4'd0;
  logic       pre_en = 1'b0;
  logic       direct_mode = 1'b0;
  logic       fp;

  int  checks = 0;
  int  fails  = 0;
  int  cycles = 0;
  bit  model_on = 1'b1;
  bit  started = 1'b0;
  int  rem = 0;
  bit  exp_fp = 1'b0;
  int  pulse_cnt = 0;
  string cur_req = "R8";

  always #5 clk = ~clk;

  pulse_swallow_divider dut_i (
    .clk_in      (clk),
    .rst_n       (rst_n),
    .m_val       (m_val),
    .a_val       (a_val),
    .pre_en      (pre_en),
    .direct_mode (direct_mode),
    .fp          (fp)
  );

  function automatic int period_of(input logic [8:0] m, input logic [3:0] a,
                                   input logic byp, input logic dm);
    int me;
    me = dm ? int'(m & 9'd127) : int'(m);
    if (byp) return me + 1;
    return 10 * (me + 1) + int'(a);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Behavioural reference: period length from inputs sampled at each boundary.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      started = 1'b0;
      exp_fp  = 1'b0;
    end else if (!started) begin
      started = 1'b1;
      rem     = period_of(m_val, a_val, pre_en, direct_mode);
      exp_fp  = 1'b0;
    end else begin
      rem--;
      if (rem == 0) begin
        exp_fp = 1'b1;
        rem    = period_of(m_val, a_val, pre_en, direct_mode);
      end else begin
        exp_fp = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (fp) pulse_cnt++;
    if (model_on) begin
      check(fp === (rst_n ? exp_fp : 1'b0), cur_req, int'(fp), int'(rst_n ? exp_fp : 1'b0));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic set_cfg(input int m, input int a, input bit byp, input bit dm);
    m_val = 9'(m); a_val = 4'(a); pre_en = byp; direct_mode = dm;
  endtask

  task automatic do_reset(input int n);
    @(posedge clk); #2;
    rst_n = 1'b0;
    step(n);
    rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    // R8: reset holds fp low
    cur_req = "R8";
    set_cfg(1, 0, 1'b0, 1'b0);
    step(6);
    rst_n = 1'b1;
    // R2: minimum M, A=0 -> period 20
    cur_req = "R2";
    step(70);
    // R1: M=5, A=3 -> 63
    cur_req = "R1";
    do_reset(3);
    set_cfg(5, 3, 1'b0, 1'b0);
    step(200);
    // R3: A = M+1 boundary -> 66, and A=0 -> 60
    cur_req = "R3";
    set_cfg(5, 6, 1'b0, 1'b0);
    step(200);
    set_cfg(5, 0, 1'b0, 1'b0);
    step(200);
    // R6: mid-period change, takes effect at the next boundary only
    cur_req = "R6";
    set_cfg(5, 3, 1'b0, 1'b0);
    step(97);
    set_cfg(2, 1, 1'b0, 1'b0);
    step(20);
    set_cfg(7, 2, 1'b0, 1'b0);
    step(200);
    // R4: bypass, A ignored: M=1 -> 2, M=37 -> 38
    cur_req = "R4";
    set_cfg(1, 9, 1'b1, 1'b0);
    step(100);
    set_cfg(37, 15, 1'b1, 1'b0);
    step(150);
    // R5: direct mode masks M[8:7]: 453 -> 69, prescaled 704; bypass 70
    cur_req = "R5";
    set_cfg(453, 4, 1'b0, 1'b1);
    step(1600);
    set_cfg(453, 4, 1'b1, 1'b1);
    step(300);
    // R2: maximum M with A=15 -> 5135
    cur_req = "R2";
    set_cfg(511, 15, 1'b0, 1'b0);
    step(10600);
    // R7: first pulse latency after reset, M=3 A=2 -> 42
    cur_req = "R7";
    do_reset(2);
    set_cfg(3, 2, 1'b0, 1'b0);
    step(150);
    // R9: illegal A > M+1 must not stall
    cur_req = "R9";
    model_on = 1'b0;
    set_cfg(1, 15, 1'b0, 1'b0);
    step(60);
    pulse_cnt = 0;
    step(400);
    check(pulse_cnt >= 2, "R9", pulse_cnt, 2);
    do_reset(2);
    model_on = 1'b1;
    cur_req = "R8";
    set_cfg(2, 1, 1'b0, 1'b0);
    step(120);
    summary();
  end

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule